// File: doc/BRIEF.md
# Serial-Commanded Dual-Port DAC Level Controller

This block lets a host set sixteen static analog levels by sending short byte commands over a UART receive line. Each command names one of sixteen channels and carries a 12-bit level code. The block decodes the command and works out which of two SPI-attached DAC devices owns the channel. It then shifts a 32-bit write frame out to that device. Each device serves eight channels.

The UART receiver (states `U_IDLE`, `U_START`, `U_DATA`, `U_STOP`, `U_RECOVER`) oversamples the line 16 times per bit. It confirms the start bit at its middle and samples each data bit and the stop bit at mid-bit. A byte whose stop bit reads low is thrown away, and the receiver then goes to `U_RECOVER` and waits for the line to go high before it looks for a new start bit. The command parser (states `P_SYNC`, `P_HEAD`, `P_LOW`) moves `P_SYNC`→`P_HEAD` on a sync byte. It moves `P_HEAD`→`P_LOW` on the channel/high-code byte, and `P_LOW`→`P_SYNC` on the low-code byte, where it emits the command.

A dispatcher (states `D_IDLE`, `D_ISSUE`, `D_BUSY`) holds commands in a one-entry slot. It moves `D_IDLE`→`D_ISSUE` when the slot is full. `D_ISSUE` launches the frame on the owning port and moves to `D_BUSY`, and `D_BUSY` returns to `D_IDLE` once both ports are idle. Each SPI port (states `S_IDLE`, `S_LOW`, `S_HIGH`, `S_TAIL`) moves `S_IDLE`→`S_LOW` on a launch, and then alternates `S_LOW`↔`S_HIGH` once per bit. After the 32nd high phase it goes `S_HIGH`→`S_TAIL`, and after one more half period it goes `S_TAIL`→`S_IDLE`, where it raises chip-select.

Top module: `dac_cmd_spi_ctrl`

## Requirements
- R1: The UART line is 8N1, LSB first, idle high. Bit time is CLK_FREQ_HZ/BAUD_RATE clocks, taken as 16 oversample ticks, and every bit is sampled at its middle.
- R2: A byte whose stop bit samples low is discarded and has no effect on any output.
- R3: A command is three bytes. The first is 0xA5. The second holds the channel in bits [3:0] and code[11:8] in bits [7:4]. The third holds code[7:0].
- R4: While waiting for a command, any byte other than 0xA5 is discarded and starts no transfer. A later correct command is still accepted.
- R5: Channels 0–7 go to port A and channels 8–15 go to port B. The DAC address is channel bits [2:0].
- R6: The frame, MSB first, is bits [31:28] = DAC_OP (default 0x3), bit 27 = 0, bits [26:24] = address, bits [23:12] = code, and bits [11:0] = 0.
- R7: SPI mode 0. SCLK is low whenever chip-select is high, and MOSI changes only while SCLK is low. Exactly 32 rising SCLK edges occur inside each chip-select low window.
- R8: SCLK rising edges within a frame are SPI_DIV clocks apart, and SCLK is never high for more than SPI_DIV/2 clocks.
- R9: A command that arrives during a transfer is held and sent after the current frame. Commands leave in arrival order.
- R10: A command that arrives while the slot is already full is dropped and sets `overflow`. Only reset clears `overflow`.
- R11: After reset both chip-selects are high, both SCLKs are low and `overflow` is low.
- R12: At most one port has chip-select low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_rx | input | 1 | Serial command line from host |
| dac_a_cs_n | output | 1 | Port A chip-select, active low |
| dac_a_sclk | output | 1 | Port A serial clock |
| dac_a_mosi | output | 1 | Port A serial data |
| dac_b_cs_n | output | 1 | Port B chip-select, active low |
| dac_b_sclk | output | 1 | Port B serial clock |
| dac_b_mosi | output | 1 | Port B serial data |
| overflow | output | 1 | Sticky flag for a dropped command |

## Verification
The bench builds the block with a 200 MHz clock and a 12.5 Mbaud line, so one bit is 16 clocks and one three-byte command lasts 480 clocks. SPI_DIV is set to 32, so one SPI frame takes about 1040 clocks. With these values a second back-to-back command lands in the slot during a transfer, and a third arrives while the slot is still full. That makes both the buffering order and the overflow path reachable with directed stimulus. The short bit time also keeps the bad-stop and sync-mismatch scenarios within a few thousand cycles.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int NUM_PORTS  = 2;
    localparam int CODE_W     = 12;
    localparam int CHAN_W     = 4;
    localparam int FRAME_W    = 32;
    localparam logic [7:0] SYNC_BYTE = 8'hA5;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } dac_cmd_t;

    // Write frame: op nibble, zero, 3-bit address, code, zero pad.
    function automatic logic [FRAME_W-1:0] pack_frame(input logic [3:0] op,
                                                      input dac_cmd_t c);
        return {op, 1'b0, c.chan[2:0], c.code, 12'h000};
    endfunction

endpackage

// File: rtl/dcs_uart_rx.sv
module dcs_uart_rx #(
    parameter int TICK_DIV = 54
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    output logic [7:0] data,
    output logic       valid
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef enum logic [2:0] {U_IDLE, U_START, U_DATA, U_STOP, U_RECOVER} ustate_t;

    ustate_t        state, nxt;
    logic [1:0]     rx_sync;
    logic           rx_s;
    logic [TW-1:0]  tcnt;
    logic           tick;
    logic [3:0]     os_cnt;
    logic [2:0]     bit_idx;
    logic [7:0]     shreg;

    assign rx_s = rx_sync[1];
    assign tick = (tcnt == TW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sync <= 2'b11;
            tcnt    <= '0;
        end else begin
            rx_sync <= {rx_sync[0], rx};
            tcnt    <= tick ? '0 : tcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= U_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            U_IDLE:    if (!rx_s) nxt = U_START;
            U_START:   if (tick && os_cnt == 4'd7) nxt = rx_s ? U_IDLE : U_DATA;
            U_DATA:    if (tick && os_cnt == 4'd15 && bit_idx == 3'd7) nxt = U_STOP;
            U_STOP:    if (tick && os_cnt == 4'd15) nxt = rx_s ? U_IDLE : U_RECOVER;
            U_RECOVER: if (rx_s) nxt = U_IDLE;
            default:   nxt = U_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            data    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                U_IDLE: begin
                    os_cnt  <= '0;
                    bit_idx <= '0;
                end
                U_START: begin
                    if (tick) os_cnt <= (os_cnt == 4'd7) ? 4'd0 : os_cnt + 1'b1;
                end
                U_DATA: begin
                    if (tick) begin
                        if (os_cnt == 4'd15) begin
                            os_cnt  <= '0;
                            shreg   <= {rx_s, shreg[7:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                U_STOP: begin
                    if (tick) begin
                        os_cnt <= os_cnt + 1'b1;
                        if (os_cnt == 4'd15 && rx_s) begin
                            data  <= shreg;
                            valid <= 1'b1;
                        end
                    end
                end
                U_RECOVER: os_cnt <= '0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcs_cmd_parser.sv
module dcs_cmd_parser
    import dac_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic [7:0] byte_data,
    input  logic     byte_valid,
    output dac_cmd_t cmd,
    output logic     cmd_valid
);
    typedef enum logic [1:0] {P_SYNC, P_HEAD, P_LOW} pstate_t;

    pstate_t     state, nxt;
    logic [3:0]  chan_q;
    logic [3:0]  code_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= P_SYNC;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            P_SYNC:  if (byte_valid && byte_data == SYNC_BYTE) nxt = P_HEAD;
            P_HEAD:  if (byte_valid) nxt = P_LOW;
            P_LOW:   if (byte_valid) nxt = P_SYNC;
            default: nxt = P_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q    <= '0;
            code_hi_q <= '0;
            cmd       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            unique case (state)
                P_HEAD: if (byte_valid) begin
                    chan_q    <= byte_data[3:0];
                    code_hi_q <= byte_data[7:4];
                end
                P_LOW: if (byte_valid) begin
                    cmd.chan  <= chan_q;
                    cmd.code  <= {code_hi_q, byte_data};
                    cmd_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcs_spi_port.sv
module dcs_spi_port #(
    parameter int SPI_DIV = 4,
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               busy
);
    localparam int HALF = (SPI_DIV < 2) ? 1 : SPI_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = $clog2(FRAME_W);

    typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL} sstate_t;

    sstate_t            state, nxt;
    logic [CW-1:0]      div_cnt;
    logic [BW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               half_done;

    assign half_done = (div_cnt == CW'(HALF - 1));
    assign busy      = (state != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_LOW;
            S_LOW:   if (half_done) nxt = S_HIGH;
            S_HIGH:  if (half_done) nxt = (bit_cnt == BW'(FRAME_W - 1)) ? S_TAIL : S_LOW;
            S_TAIL:  if (half_done) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    sclk    <= 1'b0;
                    div_cnt <= '0;
                    if (start) begin
                        cs_n    <= 1'b0;
                        shreg   <= frame;
                        mosi    <= frame[FRAME_W-1];
                        bit_cnt <= '0;
                    end
                end
                S_LOW: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        sclk    <= 1'b1;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                S_HIGH: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        sclk    <= 1'b0;
                        if (bit_cnt != BW'(FRAME_W - 1)) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                            mosi    <= shreg[FRAME_W-2];
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                S_TAIL: begin
                    if (half_done) begin
                        div_cnt <= '0;
                        cs_n    <= 1'b1;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dac_cmd_spi_ctrl.sv
module dac_cmd_spi_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int         CLK_FREQ_HZ = 100_000_000,
    parameter int         BAUD_RATE   = 115_200,
    parameter int         SPI_DIV     = 4,
    parameter logic [3:0] DAC_OP      = 4'h3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_rx,
    output logic dac_a_cs_n,
    output logic dac_a_sclk,
    output logic dac_a_mosi,
    output logic dac_b_cs_n,
    output logic dac_b_sclk,
    output logic dac_b_mosi,
    output logic overflow
);
    localparam int TICK_RAW = CLK_FREQ_HZ / (BAUD_RATE * 16);
    localparam int TICK_DIV = (TICK_RAW < 1) ? 1 : TICK_RAW;

    typedef enum logic [1:0] {D_IDLE, D_ISSUE, D_BUSY} dstate_t;

    logic [7:0]         rx_byte;
    logic               rx_valid;
    dac_cmd_t           cmd;
    logic               cmd_valid;
    dac_cmd_t           slot;
    logic               slot_valid;
    logic               consume;
    dstate_t            state, nxt;
    logic [FRAME_W-1:0] frame;
    logic [NUM_PORTS-1:0] start, port_busy, cs_arr, sclk_arr, mosi_arr;

    dcs_uart_rx #(.TICK_DIV(TICK_DIV)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rx    (uart_rx),
        .data  (rx_byte),
        .valid (rx_valid)
    );

    dcs_cmd_parser u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (rx_byte),
        .byte_valid (rx_valid),
        .cmd        (cmd),
        .cmd_valid  (cmd_valid)
    );

    // One-entry holding slot with sticky drop flag
    assign consume = (state == D_ISSUE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot       <= '0;
            slot_valid <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (cmd_valid) begin
                if (!slot_valid || consume) begin
                    slot       <= cmd;
                    slot_valid <= 1'b1;
                end else begin
                    overflow <= 1'b1;
                end
            end else if (consume) begin
                slot_valid <= 1'b0;
            end
        end
    end

    // Dispatcher: one transfer at a time across both ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= D_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            D_IDLE:  if (slot_valid) nxt = D_ISSUE;
            D_ISSUE: nxt = D_BUSY;
            D_BUSY:  if (!(|port_busy)) nxt = D_IDLE;
            default: nxt = D_IDLE;
        endcase
    end

    assign frame = pack_frame(DAC_OP, slot);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            assign start[p] = consume && (slot.chan[3] == p[0]);
            dcs_spi_port #(.SPI_DIV(SPI_DIV), .FRAME_W(FRAME_W)) u_spi (
                .clk   (clk),
                .rst_n (rst_n),
                .start (start[p]),
                .frame (frame),
                .cs_n  (cs_arr[p]),
                .sclk  (sclk_arr[p]),
                .mosi  (mosi_arr[p]),
                .busy  (port_busy[p])
            );
        end
    endgenerate

    assign dac_a_cs_n = cs_arr[0];
    assign dac_a_sclk = sclk_arr[0];
    assign dac_a_mosi = mosi_arr[0];
    assign dac_b_cs_n = cs_arr[1];
    assign dac_b_sclk = sclk_arr[1];
    assign dac_b_mosi = mosi_arr[1];

endmodule

// File: rtl/dac_cmd_spi_ctrl_chk.sv
module dac_cmd_spi_ctrl_chk #(
    parameter int SPI_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic a_cs_n,
    input logic a_sclk,
    input logic a_mosi,
    input logic b_cs_n,
    input logic b_sclk,
    input logic b_mosi,
    input logic overflow
);
    localparam int HALF = (SPI_DIV < 2) ? 1 : SPI_DIV / 2;

    logic [15:0] a_hi, b_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_hi <= '0;
            b_hi <= '0;
        end else begin
            a_hi <= a_sclk ? a_hi + 1'b1 : 16'd0;
            b_hi <= b_sclk ? b_hi + 1'b1 : 16'd0;
        end
    end

    a_r7_a_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        a_cs_n |-> !a_sclk);
    a_r7_b_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        b_cs_n |-> !b_sclk);
    a_r7_a_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sclk && $past(a_sclk)) |-> $stable(a_mosi));
    a_r7_b_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sclk && $past(b_sclk)) |-> $stable(b_mosi));
    a_r8_a_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        a_hi <= 16'(HALF));
    a_r8_b_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        b_hi <= 16'(HALF));
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r12_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !(!a_cs_n && !b_cs_n));

endmodule

bind dac_cmd_spi_ctrl dac_cmd_spi_ctrl_chk #(.SPI_DIV(SPI_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_cs_n   (dac_a_cs_n),
    .a_sclk   (dac_a_sclk),
    .a_mosi   (dac_a_mosi),
    .b_cs_n   (dac_b_cs_n),
    .b_sclk   (dac_b_sclk),
    .b_mosi   (dac_b_mosi),
    .overflow (overflow)
);

// File: tb/dac_cmd_spi_ctrl_bench.sv
`timescale 1ns/1ps
module dac_cmd_spi_ctrl_bench;
    localparam int CLK_HZ = 200_000_000;
    localparam int BAUD   = 12_500_000;
    localparam int BITC   = CLK_HZ / BAUD;
    localparam int DIV    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic a_cs, a_sclk, a_mosi, b_cs, b_sclk, b_mosi, ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_cmd_spi_ctrl #(.CLK_FREQ_HZ(CLK_HZ), .BAUD_RATE(BAUD), .SPI_DIV(DIV)) u_dac_cmd_spi_ctrl (
        .clk(clk), .rst_n(rst_n), .uart_rx(rx),
        .dac_a_cs_n(a_cs), .dac_a_sclk(a_sclk), .dac_a_mosi(a_mosi),
        .dac_b_cs_n(b_cs), .dac_b_sclk(b_sclk), .dac_b_mosi(b_mosi),
        .overflow(ovf)
    );

    // SPI capture monitor
    logic [31:0] frames [0:1][0:15];
    int          fcnt [0:1];
    logic [31:0] sh [0:1];
    int          nb [0:1];
    int          last_rise [0:1];
    int          per_err = 0;
    int          bits_err = 0;
    logic [1:0]  prev_cs = 2'b11, prev_sclk = 2'b00;

    initial begin
        for (int p = 0; p < 2; p++) begin
            fcnt[p] = 0; sh[p] = '0; nb[p] = 0; last_rise[p] = 0;
        end
    end

    always @(negedge clk) begin
        logic [1:0] cs, sc, mo;
        cs = {b_cs, a_cs};
        sc = {b_sclk, a_sclk};
        mo = {b_mosi, a_mosi};
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (!cs[p] && prev_cs[p]) nb[p] = 0;
                if (!cs[p] && sc[p] && !prev_sclk[p]) begin
                    sh[p] = {sh[p][30:0], mo[p]};
                    if (nb[p] > 0 && (cyc - last_rise[p]) != DIV) per_err++;
                    last_rise[p] = cyc;
                    nb[p]++;
                end
                if (cs[p] && !prev_cs[p]) begin
                    if (nb[p] != 32) bits_err++;
                    if (fcnt[p] < 16) frames[p][fcnt[p]] = sh[p];
                    fcnt[p]++;
                end
            end
        end
        prev_cs = cs;
        prev_sclk = sc;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk) rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx = good_stop;
        repeat (BITC) @(negedge clk);
        rx = 1'b1;
        if (!good_stop) repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [3:0] ch, input logic [11:0] code);
        send_byte(8'hA5, 1'b1);
        send_byte({code[11:8], ch}, 1'b1);
        send_byte(code[7:0], 1'b1);
    endtask

    function automatic logic [31:0] exp_frame(input logic [3:0] ch, input logic [11:0] code);
        return {4'h3, 1'b0, ch[2:0], code, 12'h000};
    endfunction

    task automatic settle();
        repeat (2600) @(negedge clk);
    endtask

    // R11
    task automatic t_reset();
        chk(a_cs && b_cs, "R11 cs high", {30'b0, b_cs, a_cs}, 32'h3);
        chk(!a_sclk && !b_sclk, "R11 sclk low", {30'b0, b_sclk, a_sclk}, 32'h0);
        chk(!ovf, "R11 overflow low", {31'b0, ovf}, 32'h0);
    endtask

    // R1 R3 R5 R6 R7 R8
    task automatic t_single(input logic [3:0] ch, input logic [11:0] code);
        int pa, pb, port;
        pa = fcnt[0]; pb = fcnt[1];
        port = ch[3] ? 1 : 0;
        send_cmd(ch, code);
        settle();
        chk(fcnt[port] == (port ? pb : pa) + 1, "R5 frame on owning port", fcnt[port], (port ? pb : pa) + 1);
        chk(fcnt[1-port] == (port ? pa : pb), "R5 no frame on other port", fcnt[1-port], (port ? pa : pb));
        chk(frames[port][fcnt[port]-1] == exp_frame(ch, code), "R6 R3 R1 frame content",
            frames[port][fcnt[port]-1], exp_frame(ch, code));
        chk(bits_err == 0, "R7 32 edges per frame", bits_err, 0);
        chk(per_err == 0, "R8 sclk period", per_err, 0);
    endtask

    // R4
    task automatic t_sync_mismatch();
        int pa, pb;
        pa = fcnt[0]; pb = fcnt[1];
        send_byte(8'h5A, 1'b1);
        send_byte(8'h13, 1'b1);
        send_byte(8'h45, 1'b1);
        settle();
        chk(fcnt[0] == pa && fcnt[1] == pb, "R4 no transfer after bad sync", fcnt[0] + fcnt[1], pa + pb);
        t_single(4'd6, 12'h3C9);
    endtask

    // R2
    task automatic t_bad_stop();
        int pa, pb;
        pa = fcnt[0]; pb = fcnt[1];
        send_byte(8'hA5, 1'b0);
        send_byte(8'h21, 1'b1);
        send_byte(8'h34, 1'b1);
        settle();
        chk(fcnt[0] == pa && fcnt[1] == pb, "R2 bad stop byte dropped", fcnt[0] + fcnt[1], pa + pb);
        t_single(4'd11, 12'h804);
    endtask

    // R9
    task automatic t_buffer();
        int pa;
        pa = fcnt[0];
        send_cmd(4'd2, 12'h222);
        send_cmd(4'd5, 12'h555);
        settle();
        chk(fcnt[0] == pa + 2, "R9 both buffered frames sent", fcnt[0], pa + 2);
        chk(frames[0][pa] == exp_frame(4'd2, 12'h222), "R9 first frame order", frames[0][pa], exp_frame(4'd2, 12'h222));
        chk(frames[0][pa+1] == exp_frame(4'd5, 12'h555), "R9 second frame order", frames[0][pa+1], exp_frame(4'd5, 12'h555));
        chk(!ovf, "R9 no overflow for one held command", {31'b0, ovf}, 32'h0);
    endtask

    // R10
    task automatic t_overflow();
        int pb;
        pb = fcnt[1];
        send_cmd(4'd10, 12'hAAA);
        send_cmd(4'd11, 12'hBBB);
        send_cmd(4'd13, 12'hDDD);
        settle();
        chk(ovf, "R10 overflow set", {31'b0, ovf}, 32'h1);
        chk(fcnt[1] == pb + 2, "R10 third command dropped", fcnt[1], pb + 2);
        chk(frames[1][pb+1] == exp_frame(4'd11, 12'hBBB), "R10 held frame kept", frames[1][pb+1], exp_frame(4'd11, 12'hBBB));
        t_single(4'd14, 12'h0F0);
        chk(ovf, "R10 overflow sticky", {31'b0, ovf}, 32'h1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        t_reset();
        t_single(4'd3, 12'h5A7);
        t_single(4'd12, 12'hFFF);
        t_single(4'd7, 12'h000);
        t_single(4'd8, 12'h001);
        t_sync_mismatch();
        t_bad_stop();
        t_buffer();
        t_overflow();
        finish_run();
    end

    initial begin
        #(5 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

endmodule